// File: doc/BRIEF.md
# Fixed-Priority Bus Arbiter with Owner Release Points

This block decides which of four masters drives a shared bus. The masters are, from the lowest to the highest priority, a CPU, a DMA controller, a DRAM refresh agent and an external master. Each master has a request line and an acknowledge line. The arbiter looks at every request on every clock and works out the strongest requester. The bus moves to that requester only when the current owner is at a point where it may let go.

For the CPU, these release points are the end of a bus cycle, a period of internal work (such as a multiply or divide) and sleep. An end-of-cycle strobe that comes while the CPU is in the middle of a word access made of two byte cycles is not a release point. Each of the other masters reports its release points on a strobe of its own. The CPU is the default owner: it holds the bus whenever nobody else has it. All acknowledges are registered. A handover lowers the old acknowledge and raises the new one on the same clock edge.

Top module: `bus_arbiter_rp`

## Requirements
- R1: During and after a synchronous active-high reset, `ack` equals 4'b0001, so the CPU alone is acknowledged.
- R2: Exactly one bit of `ack` is high in every cycle. At a handover, the old owner's bit falls and the new owner's bit rises on the same edge.
- R3: The bit index of `req` and `ack` is 0 for the CPU, 1 for DMA, 2 for DRAM and 3 for the external master. When the owner releases, the highest requesting index wins on the next edge. The CPU wins when no other master requests.
- R4: A CPU owner that keeps `req[0]` high, with `cpu_internal` and `cpu_sleep` low, gives up the bus only on a cycle where `cpu_cycle_end` is 1 and `cpu_pair_lock` is 0. The new acknowledge appears on the following edge.
- R5: While `cpu_pair_lock` is 1 (the first byte of a split word is in progress), `cpu_cycle_end` does not release a requesting CPU.
- R6: When `cpu_internal` or `cpu_sleep` is 1, a CPU owner releases on the next edge, whatever the values of `cpu_cycle_end` and `cpu_pair_lock`.
- R7: A CPU owner with `req[0]` low releases on the next edge.
- R8: A non-CPU owner keeps the bus while its request stays high and no higher index requests, whatever its release strobe does.
- R9: A non-CPU owner at index k is released only in a cycle where its strobe `rel_pt[k-1]` is 1. If it drops its request without the strobe, it keeps `ack`.
- R10: A higher-index request takes the bus from a non-CPU owner only in a cycle where that owner's strobe is 1, even while the owner still requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 4 | Bus requests, index 0 CPU up to 3 external |
| rel_pt | input | 3 | Release strobes of masters 1..3 (bit k-1 for master k) |
| cpu_cycle_end | input | 1 | CPU is at a bus-cycle boundary |
| cpu_pair_lock | input | 1 | CPU is between the two byte halves of a word |
| cpu_internal | input | 1 | CPU is doing internal work without the bus |
| cpu_sleep | input | 1 | CPU is asleep |
| ack | output | 4 | One-hot registered acknowledges |

## Verification
Two events can fall on the same cycle: the owner reaching a release point and a competing request from a higher master. The same holds for a CPU cycle-end strobe and a pair lock that masks it. The bench provokes these collisions with sweeps. From a CPU-owned state it drives every combination of the four requests and the four CPU status lines. From each non-CPU owner it drives every combination of requests and release strobe. Each outcome is judged against an arithmetic model of the priority and release rules, one edge later.

// File: rtl/bus_arbiter_rp_pkg.sv
package bus_arbiter_rp_pkg;
  localparam int CPU_IDX = 0;

  typedef struct packed {
    logic cyc_end;
    logic pair_lock;
    logic internal;
    logic sleep;
  } cpu_stat_t;

  function automatic logic cpu_may_release(input cpu_stat_t s, input logic cpu_req);
    return (s.cyc_end & ~s.pair_lock) | s.internal | s.sleep | ~cpu_req;
  endfunction
endpackage

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req_eff,
  output logic [N-1:0] win,
  output logic [N-1:0] above
);
  // above[i]: some index higher than i requests
  assign above[N-1] = 1'b0;
  genvar i;
  generate
    for (i = N - 2; i >= 0; i--) begin : g_above
      assign above[i] = above[i+1] | req_eff[i+1];
    end
    for (i = 0; i < N; i++) begin : g_win
      assign win[i] = req_eff[i] & ~above[i];
    end
  endgenerate
endmodule

// File: rtl/arb_release_gate.sv
module arb_release_gate
  import bus_arbiter_rp_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N-1:0] owner,
  input  logic [N-1:0] req,
  input  logic [N-1:0] above,
  input  logic [N-2:0] rel_pt,
  input  cpu_stat_t    cpu_st,
  output logic         release_ok
);
  logic [N-1:0] may_go;

  assign may_go[CPU_IDX] = cpu_may_release(cpu_st, req[CPU_IDX]);

  genvar k;
  generate
    for (k = 1; k < N; k++) begin : g_master
      // at its own boundary: either finished or outranked
      assign may_go[k] = rel_pt[k-1] & (~req[k] | above[k]);
    end
  endgenerate

  assign release_ok = |(owner & may_go);
endmodule

// File: rtl/arb_grant_reg.sv
module arb_grant_reg #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [N-1:0] next_owner,
  output logic [N-1:0] owner
);
  localparam logic [N-1:0] DEFAULT_OWNER = {{(N-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst)
      owner <= DEFAULT_OWNER;
    else if (load)
      owner <= next_owner;
  end
endmodule

// File: rtl/bus_arbiter_rp.sv
module bus_arbiter_rp
  import bus_arbiter_rp_pkg::*;
#(
  parameter int NUM_MASTERS = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_MASTERS-1:0] req,
  input  logic [NUM_MASTERS-2:0] rel_pt,
  input  logic                   cpu_cycle_end,
  input  logic                   cpu_pair_lock,
  input  logic                   cpu_internal,
  input  logic                   cpu_sleep,
  output logic [NUM_MASTERS-1:0] ack
);
  localparam int N = NUM_MASTERS;

  logic [N-1:0] req_eff, win, above;
  logic         release_ok;
  cpu_stat_t    cpu_st;

  // CPU counts as a requester always: it is the default owner
  assign req_eff = req | {{(N-1){1'b0}}, 1'b1};
  assign cpu_st  = '{cyc_end: cpu_cycle_end, pair_lock: cpu_pair_lock,
                     internal: cpu_internal, sleep: cpu_sleep};

  arb_prio_pick #(.N(N)) u_pick (
    .req_eff (req_eff),
    .win     (win),
    .above   (above)
  );

  arb_release_gate #(.N(N)) u_gate (
    .owner      (ack),
    .req        (req),
    .above      (above),
    .rel_pt     (rel_pt),
    .cpu_st     (cpu_st),
    .release_ok (release_ok)
  );

  arb_grant_reg #(.N(N)) u_grant (
    .clk        (clk),
    .rst        (rst),
    .load       (release_ok),
    .next_owner (win),
    .owner      (ack)
  );
endmodule

// File: rtl/bus_arbiter_rp_chk.sv
module bus_arbiter_rp_chk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] req,
  input logic [N-2:0] rel_pt,
  input logic         cpu_cycle_end,
  input logic         cpu_pair_lock,
  input logic         cpu_internal,
  input logic         cpu_sleep,
  input logic [N-1:0] ack
);
  localparam logic [N-1:0] CPU_ONLY = {{(N-1){1'b0}}, 1'b1};

  p_reset_cpu_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ack == CPU_ONLY));

  p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot(ack));

  p_cpu_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (ack[0] && req[0] && !cpu_cycle_end && !cpu_internal && !cpu_sleep) |=> $stable(ack));

  p_pair_lock_r5: assert property (@(posedge clk) disable iff (rst)
    (ack[0] && req[0] && cpu_pair_lock && !cpu_internal && !cpu_sleep) |=> ack[0]);

  p_sleep_go_r6: assert property (@(posedge clk) disable iff (rst)
    (ack[0] && cpu_sleep && req[N-1]) |=> ack[N-1]);

  p_idle_go_r7: assert property (@(posedge clk) disable iff (rst)
    (ack[0] && !req[0] && req[N-1]) |=> ack[N-1]);

  p_top_keep_r8: assert property (@(posedge clk) disable iff (rst)
    (ack[N-1] && req[N-1]) |=> ack[N-1]);

  p_no_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    (ack[1] && !rel_pt[0]) |=> ack[1]);

  p_preempt_r10: assert property (@(posedge clk) disable iff (rst)
    (ack[N-2] && !rel_pt[N-3]) |=> ack[N-2]);
endmodule

bind bus_arbiter_rp bus_arbiter_rp_chk #(.N(NUM_MASTERS)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .req           (req),
  .rel_pt        (rel_pt),
  .cpu_cycle_end (cpu_cycle_end),
  .cpu_pair_lock (cpu_pair_lock),
  .cpu_internal  (cpu_internal),
  .cpu_sleep     (cpu_sleep),
  .ack           (ack)
);

// File: tb/tb_bus_arbiter_rp.sv
`timescale 1ns/1ps
module tb_bus_arbiter_rp;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] req = 4'd0;
  logic [2:0] rel_pt = 3'd0;
  logic       cpu_cycle_end = 1'b0, cpu_pair_lock = 1'b0;
  logic       cpu_internal = 1'b0, cpu_sleep = 1'b0;
  logic [3:0] ack;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  bus_arbiter_rp #(.NUM_MASTERS(4)) dut (
    .clk(clk), .rst(rst), .req(req), .rel_pt(rel_pt),
    .cpu_cycle_end(cpu_cycle_end), .cpu_pair_lock(cpu_pair_lock),
    .cpu_internal(cpu_internal), .cpu_sleep(cpu_sleep), .ack(ack)
  );

  task automatic check(input string tag, input logic [3:0] exp);
    n_checks++;
    if (ack !== exp) begin
      n_fail++;
      $display("FAIL %s: ack=%b expected=%b", tag, ack, exp);
    end
  endtask

  // Model: returns next owner index from the rules in the requirements
  function automatic int model(input int own, input logic [3:0] r, input logic [2:0] rp,
                               input logic ce, input logic lk, input logic it, input logic sl);
    int  top = 0;
    bit  go;
    for (int i = 1; i < 4; i++) if (r[i]) top = i;
    if (own == 0) go = (ce && !lk) || it || sl || !r[0];
    else          go = rp[own-1] && (!r[own] || top > own);
    return go ? top : own;
  endfunction

  task automatic clear_in();
    req = 4'd0; rel_pt = 3'd0;
    cpu_cycle_end = 0; cpu_pair_lock = 0; cpu_internal = 0; cpu_sleep = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); clear_in(); rst = 1'b1;
    @(negedge clk);
    @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: ack=%b expected=completion", ack);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    // R1: reset state
    @(negedge clk); @(negedge clk);
    check("R1 during reset", 4'b0001);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", 4'b0001);

    // R3 R4 R5 R6 R7 R2: sweep all CPU-owned input patterns
    for (int v = 0; v < 256; v++) begin
      int nx;
      do_reset();
      req = v[3:0]; cpu_cycle_end = v[4]; cpu_pair_lock = v[5];
      cpu_internal = v[6]; cpu_sleep = v[7];
      nx = model(0, v[3:0], 3'd0, v[4], v[5], v[6], v[7]);
      @(negedge clk);
      check("R3/R4/R5/R6/R7 cpu sweep", 4'b0001 << nx);
    end

    // R8 R9 R10 R2: sweep from each non-CPU owner
    for (int k = 1; k < 4; k++) begin
      for (int v = 0; v < 32; v++) begin
        int nx;
        do_reset();
        req = 4'b0001 << k; cpu_sleep = 1'b1;
        @(negedge clk);
        check("R6 acquire", 4'b0001 << k);
        clear_in();
        req = v[3:0]; rel_pt = v[4] ? (3'b001 << (k-1)) : 3'd0;
        nx = model(k, v[3:0], rel_pt, 0, 0, 0, 0);
        @(negedge clk);
        check("R8/R9/R10 owner sweep", 4'b0001 << nx);
      end
    end

    // R5 then R4: locked pair held, released at unlocked boundary
    do_reset();
    req = 4'b0101; cpu_cycle_end = 1; cpu_pair_lock = 1;
    @(negedge clk); check("R5 lock first", 4'b0001);
    @(negedge clk); check("R5 lock second", 4'b0001);
    cpu_pair_lock = 0;
    @(negedge clk); check("R4 boundary handover", 4'b0100);

    // R9: drop request without strobe holds, then strobe releases
    req = 4'b0001; cpu_cycle_end = 0;
    @(negedge clk); check("R9 no strobe hold", 4'b0100);
    rel_pt = 3'b010;
    @(negedge clk); check("R9 strobe release", 4'b0001);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule